// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master end of the two-wire Ethernet station-management link. It has one clock line (MDC) and one shared data line (MDIO), split into an output value, an output enable and an input. A client pulses `start` with the direction, a 5-bit PHY address, a 5-bit register address and, for a write, 16 data bits. The block then produces the whole serial frame on its own and keeps `busy` high until the frame ends.

MDC is derived from the system clock. Each half-period lasts `HALF_DIV` system clocks, and each bit slot begins with the low half. Every frame starts with a 40-bit preamble, which is longer than the common 32-bit one. For a read, the block releases MDIO for a single turnaround cycle, shifts in the PHY's 16-bit answer, clocks one trailing cycle and then presents the result with `done`. For a write, the block drives the turnaround pattern and the data, then releases MDIO and gives one extra MDC pulse.

Top module: `mdio_frame_master`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `mdc`, `mdio_oe` and `rd_data` are all zero.
- R2: Slots 0 to 39 of every frame carry the value 1 on `mdio_o`, with `mdio_oe` high.
- R3: Slots 40 and 41 carry 0 and then 1. Slots 42 and 43 carry 1,0 for a read (`is_read`=1) and 0,1 for a write, all with `mdio_oe` high.
- R4: Slots 44 to 48 carry `phy_addr[4]` down to `phy_addr[0]`, and slots 49 to 53 carry `reg_addr[4]` down to `reg_addr[0]`, all driven.
- R5: One slot is one MDC period of 2*`HALF_DIV` system clocks, with the low half first. `mdio_o` and `mdio_oe` only change while MDC is low.
- R6: In a read, `mdio_oe` is low from slot 54 on. `mdio_i` is sampled at the MDC falling edge that ends each of slots 55 to 70, first sample into bit 15. Slot 71 is the last, so a read takes 72 MDC periods.
- R7: In a write, slots 54 and 55 carry 1 then 0 and slots 56 to 71 carry `wr_data[15]` down to `wr_data[0]`, all driven. Slot 72 has `mdio_oe` low, so a write takes 73 MDC periods.
- R8: `busy` rises the cycle after an accepted `start` and falls together with a one-cycle `done` pulse at the end of the last slot. After a read, `rd_data` holds the captured value from the `done` cycle on. A write leaves `rd_data` unchanged.
- R9: A `start` arriving while `busy` is high is ignored: the frame in progress, its length and its result are unchanged.
- R10: While idle, `mdc` and `mdio_oe` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a frame (accepted only while idle) |
| is_read | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Last value read from the PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest case to reach from the ports is the read data phase. The PHY's bits must be presented in the right MDC period, and the sample point falls at the end of the high half, which is invisible at the command port. The bench contains a small PHY model that counts MDC rising edges and puts the next answer bit on `mdio_i` at each rising edge of slots 55 to 70. A wrong slot offset or wrong sampling edge therefore shows up as a shifted or corrupted `rd_data`. The ignored-start case is reached by pulsing `start` with opposite direction and fields partway through a frame, then checking that the captured frame, its length and its result still match the original request.

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_read,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int PRE_LEN   = 40;
  localparam int HDR_END   = PRE_LEN + 14;
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int CW        = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int SW        = $clog2(FRAME_LEN + 2);

  logic [FRAME_LEN-1:0] tx_sh;
  logic [15:0]          rx_sh;
  logic [SW-1:0]        slot;
  logic [CW-1:0]        div;
  logic                 rd_op;

  wire tick      = (div == CW'(HALF_DIV - 1));
  wire last_slot = (slot == (rd_op ? SW'(FRAME_LEN - 1) : SW'(FRAME_LEN)));
  wire capture   = rd_op && (slot > SW'(HDR_END)) && (slot <= SW'(HDR_END + 16));

  assign mdio_o  = tx_sh[FRAME_LEN-1];
  assign mdio_oe = busy && ((slot < SW'(HDR_END)) || (!rd_op && (slot < SW'(FRAME_LEN))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      mdc     <= 1'b0;
      div     <= '0;
      slot    <= '0;
      rd_op   <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          rd_op <= is_read;
          slot  <= '0;
          div   <= '0;
          mdc   <= 1'b0;
          tx_sh <= {{PRE_LEN{1'b1}}, 2'b01, (is_read ? 2'b10 : 2'b01),
                    phy_addr, reg_addr, 2'b10, wr_data};
        end
      end else if (tick) begin
        div <= '0;
        mdc <= ~mdc;
        if (mdc) begin
          tx_sh <= {tx_sh[FRAME_LEN-2:0], 1'b0};
          if (capture) rx_sh <= {rx_sh[14:0], mdio_i};
          if (last_slot) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (rd_op) rd_data <= rx_sh;
          end else begin
            slot <= slot + 1'b1;
          end
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_oe_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  assert_data_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_done_ends_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (rd_op == $past(rd_op)));

endmodule

// File: tb/test_mdio_frame_master.sv
module test_mdio_frame_master;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_read = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_frame_master #(.HALF_DIV(HALF)) i_mdio_frame_master (
    .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: records each slot at the MDC rising edge and answers reads
  logic [127:0] cap_o, cap_oe;
  int           ecount = 0;
  logic [15:0]  phy_val = '0;

  always @(posedge mdc) begin
    if (ecount < 128) begin
      cap_o[ecount]  = mdio_o;
      cap_oe[ecount] = mdio_oe;
    end
    if (ecount >= 55 && ecount <= 70) mdio_i = phy_val[70 - ecount];
    else mdio_i = 1'b1;
    ecount = ecount + 1;
  end

  // {is_read, phy, reg, data}
  localparam logic [26:0] VEC [6] = '{
    {1'b0, 5'h01, 5'h00, 16'hA55A},
    {1'b1, 5'h1F, 5'h1F, 16'h8001},
    {1'b0, 5'h10, 5'h01, 16'h0000},
    {1'b1, 5'h00, 5'h10, 16'hFFFF},
    {1'b0, 5'h15, 5'h0A, 16'hFFFF},
    {1'b1, 5'h0A, 5'h15, 16'h3C96}
  };

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] dat, input bit inject);
    logic [71:0] exp_bits, act_bits, exp_oe, act_oe;
    logic [15:0] prev_rd;
    int busy_cyc, high_cyc, done_cnt, slots;
    bit first_busy;
    slots = rd ? 72 : 73;
    prev_rd = rd_data;
    ecount = 0;
    cap_o = '0;
    cap_oe = '0;
    phy_val = dat;
    busy_cyc = 0; high_cyc = 0; done_cnt = 0;
    @(negedge clk);
    start = 1'b1; is_read = rd; phy_addr = pa; reg_addr = ra; wr_data = rd ? 16'h1234 : dat;
    @(negedge clk);
    start = 1'b0;
    first_busy = busy;
    check(first_busy, "R8 busy after start", {71'b0, busy}, 72'd1);
    busy_cyc = 1;
    if (mdc) high_cyc++;
    for (int n = 0; n < 2000 && busy; n++) begin
      if (inject && n == 200) begin
        start = 1'b1; is_read = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~dat;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (busy) busy_cyc++;
      if (busy && mdc) high_cyc++;
      if (done) done_cnt++;
      if (done) begin
        check(rd_data == (rd ? dat : prev_rd), rd ? "R6 R8 R9 read data with done" : "R8 write keeps rd_data",
              {56'b0, rd_data}, {56'b0, (rd ? dat : prev_rd)});
      end
    end
    start = 1'b0;
    @(negedge clk);
    check(!done && done_cnt == 1, "R8 done single cycle", {64'b0, done_cnt[7:0]}, 72'd1);
    check(busy_cyc == slots * 2 * HALF, "R7 R6 R9 frame length", {40'b0, busy_cyc}, {40'b0, slots * 2 * HALF});
    check(high_cyc == slots * HALF && ecount == slots, "R5 mdc period", {40'b0, high_cyc}, {40'b0, slots * HALF});
    exp_bits = {40'hFF_FFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, dat};
    for (int k = 0; k < 72; k++) begin
      act_bits[71 - k] = cap_o[k];
      act_oe[71 - k]   = cap_oe[k];
      exp_oe[71 - k]   = (k < 54) || (!rd);
    end
    check(act_bits[71:32] == exp_bits[71:32], "R2 preamble", act_bits, exp_bits);
    check(act_bits[31:28] == exp_bits[31:28], "R3 start and opcode", act_bits, exp_bits);
    check(act_bits[27:18] == exp_bits[27:18], "R4 addresses", act_bits, exp_bits);
    check(act_oe == exp_oe, "R6 R7 output enable pattern", act_oe, exp_oe);
    if (!rd) begin
      check(act_bits[17:0] == exp_bits[17:0], "R7 turnaround and write data", act_bits, exp_bits);
      check(cap_oe[72] == 1'b0, "R7 trailing pulse released", {71'b0, cap_oe[72]}, 72'd0);
    end
    check(!mdc && !mdio_oe, "R10 idle after frame", {70'b0, mdc, mdio_oe}, 72'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check({busy, done, mdc, mdio_oe, rd_data} == '0, "R1 during reset",
          {52'b0, busy, done, mdc, mdio_oe, rd_data}, 72'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({busy, done, mdc, mdio_oe, rd_data} == '0, "R1 after reset",
          {52'b0, busy, done, mdc, mdio_oe, rd_data}, 72'd0);
    repeat (5) @(negedge clk);
    check(!mdc && !mdio_oe, "R10 idle before any start", {70'b0, mdc, mdio_oe}, 72'd0);

    for (int v = 0; v < 6; v++)
      run_frame(VEC[v][26], VEC[v][25:21], VEC[v][20:16], VEC[v][15:0], 1'b0);

    // R9: start pulses during a busy frame must not disturb it
    run_frame(1'b1, 5'h05, 5'h1A, 16'h5AA5, 1'b1);
    run_frame(1'b0, 5'h1B, 5'h04, 16'hC003, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule